// File: doc/BRIEF.md
# DDR Write Strobe and Data Launcher

This block sits on the controller side of a double-data-rate memory interface and launches write data. Each write command names a burst length. The block answers with a strobe that stays driven low for one clock, then toggles once per clock while a pair of words goes out. The first word of each pair goes with the strobe's rising half and the second with its falling half. After the last pair, the strobe stays driven low for one more clock, and then every output enable drops so that the shared lines float.

Write data comes from a small first-word-fall-through buffer. The block pulls one rising/falling word pair, with its byte masks, per clock through a request line. The strobe and data of each line are given per clock as two half-clock levels, so an output cell can drive them on both edges. A one-clock gap between the command and the first strobe edge models the strobe-to-clock delay. A second command can be chained exactly at the point where the previous burst has no data clocks left, and the two bursts then stream without a break. A single-cycle completion pulse follows the last data clock, so that write-recovery timing can start from it.

Top module: `ddrw_wr_strobe_gen`

## Requirements
- R1: While reset is asserted and after it is released with no command, every enable, strobe level, data word, mask, request and done output is 0.
- R2: A command accepted at clock edge c, with no data clock in progress in the following cycle, gives a preamble in cycle c: the strobe enable is 1 on every lane, both strobe half levels are 0, and the data enable is 0.
- R3: The burst-length code selects the number of data clocks: 2'b00 gives 1, 2'b01 gives 2, 2'b10 and 2'b11 give 4. These data clocks are cycles c+1 to c+n. In each data clock the data enable and the strobe enable are 1, the first-half strobe level is 1 and the second-half level is 0 on every lane.
- R4: The data request output is 1 exactly in the cycles c to c+n-1. The word pair present on the inputs at the clock edge that ends a request cycle appears on the rise and fall data outputs in the next cycle.
- R5: The rise and fall mask outputs carry the mask pair taken at the same edge as the data pair (one mask bit per 8-bit lane).
- R6: When no chained burst follows, the cycle after the last data clock is a postamble (strobe enable 1, strobe levels 0, data enable 0), and in the cycle after that all enables are 0.
- R7: A command issued exactly n clocks after the previous accepted command, where n is that command's data-clock count, is accepted, and its data clocks directly follow the previous ones with no preamble or postamble between them.
- R8: A command issued n+1 clocks after the previous accepted command is accepted, and its preamble falls in the same single cycle as the previous burst's postamble.
- R9: A command issued fewer than n clocks after the previous accepted command is ignored: it adds no request, data clock or done pulse.
- R10: The done output is 1 for one cycle, the cycle after each burst's last data clock, also when a chained burst is then streaming.
- R11: While the data enable is 0, the data and mask outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_cmd | input | 1 | Write command strobe, one cycle |
| wr_bl | input | 2 | Burst-length code of the command |
| data_req | output | 1 | Pop request to the write buffer |
| wr_rise | input | DW | Buffer word for the rising half |
| wr_fall | input | DW | Buffer word for the falling half |
| wr_mrise | input | DW/8 | Byte masks for the rising-half word |
| wr_mfall | input | DW/8 | Byte masks for the falling-half word |
| dq_oe | output | 1 | Data line output enable |
| dq_rise | output | DW | Data driven in the first half of the clock |
| dq_fall | output | DW | Data driven in the second half of the clock |
| dm_rise | output | DW/8 | Mask driven in the first half of the clock |
| dm_fall | output | DW/8 | Mask driven in the second half of the clock |
| dqs_oe | output | DW/8 | Strobe output enable per lane |
| dqs_h1 | output | DW/8 | Strobe level in the first half of the clock per lane |
| dqs_h2 | output | DW/8 | Strobe level in the second half of the clock per lane |
| wr_done | output | 1 | One-cycle pulse after the last data clock |

## Verification
Two functions can land in one cycle. In the first case, one burst's postamble shares a cycle with the next burst's preamble. In the second, the done pulse of a finished burst shares a cycle with the first data clock of a chained one. The bench provokes both by sweeping every pair of burst-length codes against command spacings of one to six clocks, which includes the spacings n and n+1. For every cycle it compares the enables, strobe levels, words, masks, request and done against a timeline computed from the command times. The same sweep issues commands too early and checks that they leave the timeline unchanged.

// File: rtl/ddrw_pkg.sv
`timescale 1ns/1ps
package ddrw_pkg;

    localparam int MAX_CLKS = 4;
    localparam int CNT_W    = $clog2(MAX_CLKS);

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_POST = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   left;
        logic               pend;
        logic [CNT_W-1:0]   pend_left;
        logic               done;
    } sched_s;

    // data clocks minus one for a burst-length code
    function automatic logic [CNT_W-1:0] bl_to_left(input logic [1:0] code);
        logic [CNT_W-1:0] r;
        case (code)
            2'b00:   r = CNT_W'(0);
            2'b01:   r = CNT_W'(1);
            default: r = CNT_W'(MAX_CLKS - 1);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ddrw_sched.sv
`timescale 1ns/1ps
module ddrw_sched
    import ddrw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_bl,
    output logic       load,
    output logic       in_pre,
    output logic       in_data,
    output logic       in_post,
    output logic       done
);

    sched_s st_d, st_q;
    logic   accept;

    always_comb begin
        st_d      = st_q;
        st_d.done = (st_q.phase == PH_DATA) && (st_q.left == '0);

        if (st_q.phase == PH_DATA && st_q.left != '0) begin
            st_d.left = st_q.left - 1'b1;
        end else if (st_q.pend) begin
            st_d.phase = PH_DATA;
            st_d.left  = st_q.pend_left;
        end else if (st_q.phase == PH_DATA) begin
            st_d.phase = PH_POST;
            st_d.left  = '0;
        end else begin
            st_d.phase = PH_IDLE;
            st_d.left  = '0;
        end

        // a new burst may start only once the engine has no data clock left
        accept         = cmd_valid && ((st_d.phase != PH_DATA) || (st_d.left == '0));
        st_d.pend      = accept;
        st_d.pend_left = accept ? bl_to_left(cmd_bl) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, left: '0, pend: 1'b0, pend_left: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign load    = (st_d.phase == PH_DATA);
    assign in_data = (st_q.phase == PH_DATA);
    assign in_pre  = st_q.pend && (st_q.phase != PH_DATA);
    assign in_post = (st_q.phase == PH_POST);
    assign done    = st_q.done;

    // R9: a waiting burst never overlaps unfinished data clocks
    p_pend_when_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend |-> ((st_q.phase != PH_DATA) || (st_q.left == '0)));

    // R10: completion is flagged only after a data clock
    p_done_after_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> $past(st_q.phase == PH_DATA));

endmodule

// File: rtl/ddrw_beat_lanes.sv
`timescale 1ns/1ps
module ddrw_beat_lanes #(
    parameter int DW     = 16,
    parameter int LANE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [DW-1:0]        rise_in,
    input  logic [DW-1:0]        fall_in,
    input  logic [DW/LANE_W-1:0] mrise_in,
    input  logic [DW/LANE_W-1:0] mfall_in,
    output logic [DW-1:0]        rise_out,
    output logic [DW-1:0]        fall_out,
    output logic [DW/LANE_W-1:0] mrise_out,
    output logic [DW/LANE_W-1:0] mfall_out
);

    localparam int LANES = DW / LANE_W;

    typedef struct packed {
        logic [DW-1:0]    rise;
        logic [DW-1:0]    fall;
        logic [LANES-1:0] mrise;
        logic [LANES-1:0] mfall;
    } beat_s;

    beat_s            bt_d, bt_q;
    logic [DW-1:0]    rise_n, fall_n;
    logic [LANES-1:0] mrise_n, mfall_n;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rise_n[g*LANE_W +: LANE_W] = load ? rise_in[g*LANE_W +: LANE_W] : '0;
        assign fall_n[g*LANE_W +: LANE_W] = load ? fall_in[g*LANE_W +: LANE_W] : '0;
        assign mrise_n[g]                 = load & mrise_in[g];
        assign mfall_n[g]                 = load & mfall_in[g];
    end

    always_comb begin
        bt_d       = bt_q;
        bt_d.rise  = rise_n;
        bt_d.fall  = fall_n;
        bt_d.mrise = mrise_n;
        bt_d.mfall = mfall_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bt_q <= '0;
        end else begin
            bt_q <= bt_d;
        end
    end

    assign rise_out  = bt_q.rise;
    assign fall_out  = bt_q.fall;
    assign mrise_out = bt_q.mrise;
    assign mfall_out = bt_q.mfall;

    // R4: a word pair is taken only at a requested edge
    p_capture_on_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load) |-> (bt_q.rise == '0 && bt_q.fall == '0));

endmodule

// File: rtl/ddrw_strobe_lanes.sv
`timescale 1ns/1ps
module ddrw_strobe_lanes #(
    parameter int LANES = 2
) (
    input  logic             in_pre,
    input  logic             in_data,
    input  logic             in_post,
    output logic [LANES-1:0] oe,
    output logic [LANES-1:0] half1,
    output logic [LANES-1:0] half2
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign oe[g]    = in_pre | in_data | in_post;
        assign half1[g] = in_data;
        assign half2[g] = 1'b0;
    end

endmodule

// File: rtl/ddrw_wr_strobe_gen.sv
`timescale 1ns/1ps
module ddrw_wr_strobe_gen #(
    parameter int DW     = 16,
    parameter int LANE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_cmd,
    input  logic [1:0]           wr_bl,
    output logic                 data_req,
    input  logic [DW-1:0]        wr_rise,
    input  logic [DW-1:0]        wr_fall,
    input  logic [DW/LANE_W-1:0] wr_mrise,
    input  logic [DW/LANE_W-1:0] wr_mfall,
    output logic                 dq_oe,
    output logic [DW-1:0]        dq_rise,
    output logic [DW-1:0]        dq_fall,
    output logic [DW/LANE_W-1:0] dm_rise,
    output logic [DW/LANE_W-1:0] dm_fall,
    output logic [DW/LANE_W-1:0] dqs_oe,
    output logic [DW/LANE_W-1:0] dqs_h1,
    output logic [DW/LANE_W-1:0] dqs_h2,
    output logic                 wr_done
);

    localparam int LANES = DW / LANE_W;

    logic load, in_pre, in_data, in_post;

    ddrw_sched u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (wr_cmd),
        .cmd_bl    (wr_bl),
        .load      (load),
        .in_pre    (in_pre),
        .in_data   (in_data),
        .in_post   (in_post),
        .done      (wr_done)
    );

    ddrw_beat_lanes #(.DW(DW), .LANE_W(LANE_W)) u_beats (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .rise_in   (wr_rise),
        .fall_in   (wr_fall),
        .mrise_in  (wr_mrise),
        .mfall_in  (wr_mfall),
        .rise_out  (dq_rise),
        .fall_out  (dq_fall),
        .mrise_out (dm_rise),
        .mfall_out (dm_fall)
    );

    ddrw_strobe_lanes #(.LANES(LANES)) u_strobe (
        .in_pre  (in_pre),
        .in_data (in_data),
        .in_post (in_post),
        .oe      (dqs_oe),
        .half1   (dqs_h1),
        .half2   (dqs_h2)
    );

    assign data_req = load;
    assign dq_oe    = in_data;

    // R4: every request is followed by a data clock
    p_req_then_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        data_req |=> dq_oe);

    // R2: the first data clock of a stream is preceded by a driven strobe
    p_preamble_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> $past(dqs_oe[0]));

    // R3: data clocks toggle the strobe on every lane
    p_strobe_toggles_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> ((&dqs_oe) && (&dqs_h1) && !(|dqs_h2)));

    // R6: the end of a stream leaves the strobe driven low
    p_postamble_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dq_oe) |-> (dqs_oe[0] && !dqs_h1[0] && !dqs_h2[0]));

    // R10: done follows a data clock
    p_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> $past(dq_oe));

    // R11: floating data carries no value
    p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> (dq_rise == '0 && dq_fall == '0 && dm_rise == '0 && dm_fall == '0));

endmodule

// File: tb/ddrw_wr_strobe_gen_tb_top.sv
`timescale 1ns/1ps
module ddrw_wr_strobe_gen_tb_top;

    localparam int DW = 16;
    localparam int LN = DW / 8;
    localparam int T  = 19;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_cmd = 1'b0;
    logic [1:0]    wr_bl = 2'b00;
    logic          data_req;
    logic [DW-1:0] wr_rise = '0, wr_fall = '0;
    logic [LN-1:0] wr_mrise = '0, wr_mfall = '0;
    logic          dq_oe;
    logic [DW-1:0] dq_rise, dq_fall;
    logic [LN-1:0] dm_rise, dm_fall, dqs_oe, dqs_h1, dqs_h2;
    logic          wr_done;

    int n_run = 0;
    int n_fail = 0;
    bit ended = 1'b0;

    bit e_pre [0:31];
    bit e_req [0:31];
    bit e_dat [0:31];
    bit e_post[0:31];
    bit e_done[0:31];

    always #10 clk = ~clk;

    ddrw_wr_strobe_gen #(.DW(DW), .LANE_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .wr_bl(wr_bl),
        .data_req(data_req), .wr_rise(wr_rise), .wr_fall(wr_fall),
        .wr_mrise(wr_mrise), .wr_mfall(wr_mfall), .dq_oe(dq_oe),
        .dq_rise(dq_rise), .dq_fall(dq_fall), .dm_rise(dm_rise),
        .dm_fall(dm_fall), .dqs_oe(dqs_oe), .dqs_h1(dqs_h1),
        .dqs_h2(dqs_h2), .wr_done(wr_done)
    );

    function automatic int nclk(input int code);
        return (code == 0) ? 1 : (code == 1) ? 2 : 4;
    endfunction

    function automatic logic [DW-1:0] f_rise(input int s, input int t);
        return DW'(s * 256 + t * 37 + 5);
    endfunction
    function automatic logic [DW-1:0] f_fall(input int s, input int t);
        return DW'(s * 113 + t * 91 + 3) ^ 16'h5A5A;
    endfunction
    function automatic logic [LN-1:0] f_mr(input int s, input int t);
        return LN'(s + t);
    endfunction
    function automatic logic [LN-1:0] f_mf(input int s, input int t);
        return LN'(s + 2 * t + 1);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic mark(input int c, input int n);
        e_pre[c] = 1'b1;
        for (int j = c; j < c + n; j++) e_req[j] = 1'b1;
        for (int j = c + 1; j <= c + n; j++) e_dat[j] = 1'b1;
        e_post[c + n + 1] = 1'b1;
        e_done[c + n + 1] = 1'b1;
    endtask

    task automatic check_cycle(input int s, input int j, input string sc);
        string tg;
        bit    strobe_on;
        strobe_on = e_dat[j] | e_pre[j] | e_post[j];
        if (e_pre[j] && e_post[j] && !e_dat[j]) tg = "R8";
        else if (e_pre[j] && !e_dat[j])         tg = "R2";
        else if (e_post[j] && !e_dat[j])        tg = "R6";
        else if (e_dat[j])                      tg = "R3";
        else                                    tg = "R11";
        check($sformatf("R4 %s s%0d c%0d data_req", sc, s, j), 32'(data_req), 32'(e_req[j]));
        check($sformatf("R3 %s s%0d c%0d dq_oe", sc, s, j), 32'(dq_oe), 32'(e_dat[j]));
        check($sformatf("%s %s s%0d c%0d dqs_oe", tg, sc, s, j), 32'(dqs_oe), 32'({LN{strobe_on}}));
        check($sformatf("%s %s s%0d c%0d dqs_h1", tg, sc, s, j), 32'(dqs_h1), 32'({LN{e_dat[j]}}));
        check($sformatf("%s %s s%0d c%0d dqs_h2", tg, sc, s, j), 32'(dqs_h2), 32'(0));
        check($sformatf("R4 %s s%0d c%0d dq_rise", sc, s, j), 32'(dq_rise), e_dat[j] ? 32'(f_rise(s, j)) : 32'(0));
        check($sformatf("R4 %s s%0d c%0d dq_fall", sc, s, j), 32'(dq_fall), e_dat[j] ? 32'(f_fall(s, j)) : 32'(0));
        check($sformatf("R5 %s s%0d c%0d dm_rise", sc, s, j), 32'(dm_rise), e_dat[j] ? 32'(f_mr(s, j)) : 32'(0));
        check($sformatf("R5 %s s%0d c%0d dm_fall", sc, s, j), 32'(dm_fall), e_dat[j] ? 32'(f_mf(s, j)) : 32'(0));
        check($sformatf("R10 %s s%0d c%0d wr_done", sc, s, j), 32'(wr_done), 32'(e_done[j]));
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    task automatic check_idle(input string tg);
        check({tg, " dq_oe"}, 32'(dq_oe), 0);
        check({tg, " dqs_oe"}, 32'(dqs_oe), 0);
        check({tg, " dqs_h1"}, 32'(dqs_h1), 0);
        check({tg, " data_req"}, 32'(data_req), 0);
        check({tg, " dq_rise"}, 32'(dq_rise), 0);
        check({tg, " dm_fall"}, 32'(dm_fall), 0);
        check({tg, " wr_done"}, 32'(wr_done), 0);
    endtask

    initial begin
        int s;
        repeat (3) @(negedge clk);
        check_idle("R1 in reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_idle("R1 after reset");

        s = 0;
        for (int b1 = 0; b1 < 4; b1++) begin
            for (int b2 = 0; b2 < 4; b2++) begin
                for (int g = 1; g <= 6; g++) begin
                    int    n1;
                    string sc;
                    n1 = nclk(b1);
                    for (int k = 0; k < 32; k++) begin
                        e_pre[k] = 0; e_req[k] = 0; e_dat[k] = 0; e_post[k] = 0; e_done[k] = 0;
                    end
                    mark(0, n1);
                    if (g >= n1) mark(g, nclk(b2));
                    if (g < n1)           sc = "R9";
                    else if (g == n1)     sc = "R7";
                    else if (g == n1 + 1) sc = "R8";
                    else                  sc = "R6";
                    for (int t = 0; t < T; t++) begin
                        @(negedge clk);
                        if (t > 0) check_cycle(s, t - 1, sc);
                        wr_cmd   = (t == 0) || (t == g);
                        wr_bl    = (t == 0) ? 2'(b1) : 2'(b2);
                        wr_rise  = f_rise(s, t);
                        wr_fall  = f_fall(s, t);
                        wr_mrise = f_mr(s, t);
                        wr_mfall = f_mf(s, t);
                    end
                    wr_cmd = 1'b0;
                    s++;
                end
            end
        end
        @(negedge clk);
        check_idle("R11 final idle");
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

endmodule